// File: doc/BRIEF.md
# Audio Sample Format Converter

This block reformats a stream of audio frames between two formats: the format used by a client device and the format used on the hub side. Each frame carries up to eight samples. Each sample is a two's-complement value, left-justified in a 32-bit lane. A static set of control inputs gives both formats, each as a sample width and a channel count. A direction bit picks which of the two formats is the source.

For each frame the block first widens or narrows every sample to the destination width. It then maps the channels to the destination count. Widening fills the new low bits from a choice of zeros, ones or a free-running pseudo-random sequence. Narrowing either drops the low bits or rounds to nearest with saturation. Two-to-one channel conversion keeps one of the channels or their average. One-to-two conversion either copies the mono sample into the second channel or leaves that channel silent.

Frames pass through a single register stage with valid/ready handshaking on both sides. The control inputs are taken only while that stage holds no frame. A frame, and any burst that follows it without a gap, keeps the settings in force when the stage was last empty.

Top module: `afmt_conv`

## Requirements
- R1: A width code c (3 bits) means 4*(c+1) bits, so codes 0 to 7 give 4 to 32 bits. Input bits below the source width are ignored. Every output lane has all bits below the destination width at zero.
- R2: When cfg_dir is 0, the client fields (cfg_cli_bits, cfg_cli_ch) describe the source and the hub fields describe the destination. When cfg_dir is 1, the roles are swapped.
- R3: When the destination is wider, the bits between the two widths are filled according to cfg_fill: code 0 fills zeros and code 1 fills ones.
- R4: With cfg_fill code 2, the fill bits are taken from the same bit positions of a 32-bit word made of two copies of a 16-bit LFSR state. The LFSR is seeded to 0xACE1 on reset, shifts left with feedback bit15^bit13^bit12^bit10 into bit 0, and advances once per accepted frame. An accepted frame uses the state held before its own advance.
- R5: When the destination is narrower and cfg_chop is 1, the source bits below the destination width are discarded.
- R6: When the destination is narrower and cfg_chop is 0, half of one destination LSB is added and the sum is then truncated. A positive value that would overflow saturates to the largest positive destination value.
- R7: With a source of 2 channels and a destination of 1 channel, cfg_down selects the result: code 1 gives channel 1, code 2 gives the arithmetic mean (33-bit sum shifted right by one, then cleared below the destination width), and codes 0 and 3 give channel 0. Lane 1 of the output is zero.
- R8: With a source of 1 channel and a destination of 2 channels, lane 1 is a copy of lane 0 when cfg_up is 1 and zero when cfg_up is 0.
- R9: Channel fields hold the count minus one. For every other pair of counts, lane i passes through when i is below both counts and is zero otherwise.
- R10: After reset out_valid is 0 and in_ready is 1. An accepted frame appears on out_data one cycle later with out_valid high. While out_valid is high and out_ready is low, in_ready is low and out_data holds its value.
- R11: While out_valid is high, changes on the control inputs affect neither the pending frame nor frames accepted back to back after it. They take effect for the first frame accepted after a cycle in which out_valid was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Block can take a frame |
| in_data | input | NUM_LANES*32 | Input frame, lane i at bits [32*i+31:32*i] |
| out_valid | output | 1 | Output frame valid |
| out_ready | input | 1 | Consumer takes the output frame |
| out_data | output | NUM_LANES*32 | Converted frame |
| cfg_dir | input | 1 | 0: client to hub, 1: hub to client |
| cfg_hub_bits | input | 3 | Hub-side width code |
| cfg_cli_bits | input | 3 | Client-side width code |
| cfg_hub_ch | input | 3 | Hub-side channel count minus one |
| cfg_cli_ch | input | 3 | Client-side channel count minus one |
| cfg_fill | input | 2 | Widening fill: 0 zeros, 1 ones, 2 LFSR |
| cfg_chop | input | 1 | Narrowing: 0 round, 1 drop bits |
| cfg_down | input | 2 | Two-to-one: 0 ch0, 1 ch1, 2 mean |
| cfg_up | input | 1 | One-to-two: 0 zero, 1 copy |

## Verification
The two functions that can coincide are the release of a pending frame and the acceptance of the next one. These happen in one cycle when out_ready and in_valid are both high. A change on the control inputs can arrive in that same cycle. The bench provokes this by driving a back-to-back burst and changing the width settings while the first frame is still pending. It judges the result by requiring that the second frame still carries the old widths, and that the new widths show only on a frame sent after the output stage has emptied.

// File: rtl/afmt_pkg.sv
package afmt_pkg;

   localparam int LANE_W = 32;
   localparam int CODE_W = 3;
   localparam int WID_W  = 6;

   typedef logic [LANE_W-1:0] lane_t;

   typedef enum logic [1:0] {
      FILL_ZERO = 2'd0,
      FILL_ONE  = 2'd1,
      FILL_LFSR = 2'd2
   } fill_e;

   typedef enum logic [1:0] {
      DMX_CH0 = 2'd0,
      DMX_CH1 = 2'd1,
      DMX_AVG = 2'd2
   } downmix_e;

   typedef struct packed {
      logic              dir;
      logic [CODE_W-1:0] hub_bits;
      logic [CODE_W-1:0] cli_bits;
      logic [CODE_W-1:0] hub_ch;
      logic [CODE_W-1:0] cli_ch;
      logic [1:0]        fill;
      logic              chop;
      logic [1:0]        down;
      logic              up;
   } cfg_t;

   // width code to bit count: 4 * (code + 1)
   function automatic logic [WID_W-1:0] code_width(input logic [CODE_W-1:0] c);
      return {1'b0, c, 2'b00} + WID_W'(4);
   endfunction

   // mask keeping the top w bits of a lane
   function automatic lane_t top_mask(input logic [WID_W-1:0] w);
      return ~({LANE_W{1'b1}} >> w);
   endfunction

   // half of one LSB at width w
   function automatic lane_t half_lsb(input logic [WID_W-1:0] w);
      return {1'b1, {(LANE_W-1){1'b0}}} >> w;
   endfunction

endpackage

// File: rtl/afmt_lfsr.sv
module afmt_lfsr #(
   parameter int               WIDTH    = 16,
   parameter logic [WIDTH-1:0] TAP_MASK = 16'hB400,
   parameter logic [WIDTH-1:0] SEED     = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [WIDTH-1:0] state
);

   generate
      if (SEED == '0) begin : g_bad_seed
         $error("afmt_lfsr: SEED must be nonzero");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("afmt_lfsr: WIDTH too small");
      end
   endgenerate

   logic feedback;
   assign feedback = ^(state & TAP_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n)    state <= SEED;
      else if (step) state <= {state[WIDTH-2:0], feedback};
   end

endmodule

// File: rtl/afmt_resize.sv
module afmt_resize
   import afmt_pkg::*;
(
   input  lane_t            din,
   input  logic [WID_W-1:0] src_w,
   input  logic [WID_W-1:0] dst_w,
   input  logic [1:0]       fill_mode,
   input  logic             chop,
   input  lane_t            fill_pat,
   output lane_t            dout
);

   lane_t src_m, dst_m, v, sum, fill_v;

   always_comb begin
      src_m = top_mask(src_w);
      dst_m = top_mask(dst_w);
      v     = din & src_m;
      sum   = v + half_lsb(dst_w);
      case (fill_mode)
         FILL_ONE:  fill_v = '1;
         FILL_LFSR: fill_v = fill_pat;
         default:   fill_v = '0;
      endcase
      if (dst_w > src_w) begin
         dout = v | (fill_v & dst_m & ~src_m);
      end else if (dst_w < src_w) begin
         if (chop)
            dout = v & dst_m;
         else if (!v[LANE_W-1] && sum[LANE_W-1])
            dout = {1'b0, {(LANE_W-1){1'b1}}} & dst_m;
         else
            dout = sum & dst_m;
      end else begin
         dout = v;
      end
   end

endmodule

// File: rtl/afmt_chmap.sv
module afmt_chmap
   import afmt_pkg::*;
#(
   parameter int NUM_LANES = 8,
   localparam int BUS_W = NUM_LANES * LANE_W
) (
   input  logic [BUS_W-1:0]  lanes_i,
   input  logic [CODE_W-1:0] src_ch,
   input  logic [CODE_W-1:0] dst_ch,
   input  logic [1:0]        down,
   input  logic              up,
   input  logic [WID_W-1:0]  dst_w,
   output logic [BUS_W-1:0]  lanes_o
);

   lane_t        li [NUM_LANES];
   lane_t        lo [NUM_LANES];
   logic [LANE_W:0] pair_sum;
   lane_t        mean;

   genvar g;
   generate
      for (g = 0; g < NUM_LANES; g++) begin : g_unpack
         assign li[g] = lanes_i[g*LANE_W +: LANE_W];
         assign lanes_o[g*LANE_W +: LANE_W] = lo[g];
      end
   endgenerate

   always_comb begin
      pair_sum = {li[0][LANE_W-1], li[0]} + {li[1][LANE_W-1], li[1]};
      mean     = pair_sum[LANE_W:1] & top_mask(dst_w);
      for (int i = 0; i < NUM_LANES; i++) lo[i] = '0;
      if (src_ch == CODE_W'(1) && dst_ch == CODE_W'(0)) begin
         case (down)
            DMX_CH1: lo[0] = li[1];
            DMX_AVG: lo[0] = mean;
            default: lo[0] = li[0];
         endcase
      end else if (src_ch == CODE_W'(0) && dst_ch == CODE_W'(1)) begin
         lo[0] = li[0];
         lo[1] = up ? li[0] : '0;
      end else begin
         for (int i = 0; i < NUM_LANES; i++)
            if (i <= int'(src_ch) && i <= int'(dst_ch)) lo[i] = li[i];
      end
   end

endmodule

// File: rtl/afmt_conv.sv
module afmt_conv
   import afmt_pkg::*;
#(
   parameter int                NUM_LANES = 8,
   parameter int                LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [NUM_LANES*LANE_W-1:0] in_data,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [NUM_LANES*LANE_W-1:0] out_data,
   input  logic                        cfg_dir,
   input  logic [2:0]                  cfg_hub_bits,
   input  logic [2:0]                  cfg_cli_bits,
   input  logic [2:0]                  cfg_hub_ch,
   input  logic [2:0]                  cfg_cli_ch,
   input  logic [1:0]                  cfg_fill,
   input  logic                        cfg_chop,
   input  logic [1:0]                  cfg_down,
   input  logic                        cfg_up
);

   localparam int BUS_W  = NUM_LANES * LANE_W;
   localparam int N_COPY = LANE_W / LFSR_W;

   generate
      if (NUM_LANES < 2 || NUM_LANES > 8) begin : g_bad_lanes
         $error("afmt_conv: NUM_LANES must be 2..8");
      end
      if (LANE_W % LFSR_W != 0) begin : g_bad_lfsr
         $error("afmt_conv: LFSR_W must divide the lane width");
      end
   endgenerate

   cfg_t cfg_in, cfg_q, cfg_eff;
   logic accept;

   assign cfg_in = '{dir: cfg_dir, hub_bits: cfg_hub_bits, cli_bits: cfg_cli_bits,
                     hub_ch: cfg_hub_ch, cli_ch: cfg_cli_ch, fill: cfg_fill,
                     chop: cfg_chop, down: cfg_down, up: cfg_up};

   // settings are only picked up while the output stage is empty
   assign cfg_eff  = out_valid ? cfg_q : cfg_in;
   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   logic [CODE_W-1:0] src_code, dst_code, src_ch, dst_ch;
   logic [WID_W-1:0]  src_w, dst_w;

   assign src_code = cfg_eff.dir ? cfg_eff.hub_bits : cfg_eff.cli_bits;
   assign dst_code = cfg_eff.dir ? cfg_eff.cli_bits : cfg_eff.hub_bits;
   assign src_ch   = cfg_eff.dir ? cfg_eff.hub_ch   : cfg_eff.cli_ch;
   assign dst_ch   = cfg_eff.dir ? cfg_eff.cli_ch   : cfg_eff.hub_ch;
   assign src_w    = code_width(src_code);
   assign dst_w    = code_width(dst_code);

   // settings of the frame held on the output (used by the checker)
   logic [WID_W-1:0]  frame_dst_w;
   logic [CODE_W-1:0] frame_dst_ch;
   assign frame_dst_w  = code_width(cfg_q.dir ? cfg_q.cli_bits : cfg_q.hub_bits);
   assign frame_dst_ch = cfg_q.dir ? cfg_q.cli_ch : cfg_q.hub_ch;

   logic [LFSR_W-1:0] lfsr_state;
   lane_t             fill_pat;

   afmt_lfsr #(
      .WIDTH    (LFSR_W),
      .TAP_MASK (LFSR_TAPS),
      .SEED     (LFSR_SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (accept),
      .state (lfsr_state)
   );

   assign fill_pat = {N_COPY{lfsr_state}};

   logic [BUS_W-1:0] resized, mapped;

   genvar g;
   generate
      for (g = 0; g < NUM_LANES; g++) begin : g_lane
         afmt_resize u_rs (
            .din       (in_data[g*LANE_W +: LANE_W]),
            .src_w     (src_w),
            .dst_w     (dst_w),
            .fill_mode (cfg_eff.fill),
            .chop      (cfg_eff.chop),
            .fill_pat  (fill_pat),
            .dout      (resized[g*LANE_W +: LANE_W])
         );
      end
   endgenerate

   afmt_chmap #(.NUM_LANES(NUM_LANES)) u_map (
      .lanes_i (resized),
      .src_ch  (src_ch),
      .dst_ch  (dst_ch),
      .down    (cfg_eff.down),
      .up      (cfg_eff.up),
      .dst_w   (dst_w),
      .lanes_o (mapped)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         cfg_q <= cfg_eff;
         if (accept) begin
            out_valid <= 1'b1;
            out_data  <= mapped;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/afmt_conv_chk.sv
module afmt_conv_chk
   import afmt_pkg::*;
#(
   parameter int NUM_LANES = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic                        in_ready,
   input logic                        out_valid,
   input logic                        out_ready,
   input logic [NUM_LANES*LANE_W-1:0] out_data,
   input cfg_t                        cfg_q,
   input logic [WID_W-1:0]            frame_dst_w,
   input logic [CODE_W-1:0]           frame_dst_ch
);

   logic low_ok, hi_ok;

   always_comb begin
      low_ok = 1'b1;
      hi_ok  = 1'b1;
      for (int i = 0; i < NUM_LANES; i++) begin
         if ((out_data[i*LANE_W +: LANE_W] & ~top_mask(frame_dst_w)) != '0) low_ok = 1'b0;
         if (i > int'(frame_dst_ch) && out_data[i*LANE_W +: LANE_W] != '0) hi_ok = 1'b0;
      end
   end

   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   assert_accept_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   assert_low_bits_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> low_ok);

   assert_unused_lanes_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> hi_ok);

   assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> $stable(cfg_q));

endmodule

bind afmt_conv afmt_conv_chk #(.NUM_LANES(NUM_LANES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_data     (out_data),
   .cfg_q        (cfg_q),
   .frame_dst_w  (frame_dst_w),
   .frame_dst_ch (frame_dst_ch)
);

// File: tb/sim_afmt_conv.sv
`timescale 1ns/1ps
module sim_afmt_conv;

   localparam int BW = 256;
   localparam logic [31:0] JUNK = 32'hDEAD_BEEF;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
   logic [BW-1:0] in_data = '0, out_data;
   logic          cfg_dir = 0, cfg_chop = 0, cfg_up = 0;
   logic [2:0]    cfg_hub_bits = 0, cfg_cli_bits = 0, cfg_hub_ch = 0, cfg_cli_ch = 0;
   logic [1:0]    cfg_fill = 0, cfg_down = 0;

   int n_run = 0, n_fail = 0;

   afmt_conv u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .cfg_dir(cfg_dir), .cfg_hub_bits(cfg_hub_bits),
      .cfg_cli_bits(cfg_cli_bits), .cfg_hub_ch(cfg_hub_ch), .cfg_cli_ch(cfg_cli_ch),
      .cfg_fill(cfg_fill), .cfg_chop(cfg_chop), .cfg_down(cfg_down), .cfg_up(cfg_up)
   );

   // independent model of the fill sequence from R4
   logic [15:0] lfsr_m = 16'hACE1;
   always @(posedge clk) begin
      if (!rst_n) lfsr_m <= 16'hACE1;
      else if (in_valid && in_ready)
         lfsr_m <= {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
   end

   function automatic logic [BW-1:0] mk(input logic [31:0] a, b, c, d);
      return {JUNK, JUNK, JUNK, JUNK, d, c, b, a};
   endfunction

   function automatic logic [BW-1:0] ex(input logic [31:0] a, b, c, d);
      return {128'h0, d, c, b, a};
   endfunction

   task automatic chk(input string req, input logic [BW-1:0] got, exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic setcfg(input logic d, input logic [2:0] hb, cb, hc, cc,
                         input logic [1:0] fl, input logic ch,
                         input logic [1:0] dn, input logic u);
      @(negedge clk);
      cfg_dir = d; cfg_hub_bits = hb; cfg_cli_bits = cb; cfg_hub_ch = hc;
      cfg_cli_ch = cc; cfg_fill = fl; cfg_chop = ch; cfg_down = dn; cfg_up = u;
   endtask

   task automatic xfer(input logic [BW-1:0] d, output logic [BW-1:0] r,
                       output logic [15:0] lf);
      @(negedge clk);
      lf = lfsr_m; in_data = d; in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      r = out_data;
      chk("R10 valid after accept", {255'h0, out_valid}, {255'h0, 1'b1});
      @(negedge clk);
   endtask

   logic [BW-1:0] r;
   logic [15:0]   lf;

   task automatic t_reset;
      chk("R10 reset out_valid", {255'h0, out_valid}, '0);
      chk("R10 reset in_ready", {255'h0, in_ready}, {255'h0, 1'b1});
   endtask

   task automatic t_passthru; // R1, R9
      setcfg(0, 3'd3, 3'd3, 3'd0, 3'd0, 2'd0, 0, 2'd0, 0);
      xfer(mk(32'h1234_5678, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333), r, lf);
      chk("R1 equal width masks low bits", r, ex(32'h1234_0000, 0, 0, 0));
   endtask

   task automatic t_widen_const; // R3
      setcfg(0, 3'd5, 3'd3, 3'd0, 3'd0, 2'd0, 0, 2'd0, 0);
      xfer(mk(32'h8001_FFFF, 0, 0, 0), r, lf);
      chk("R3 widen zero fill", r, ex(32'h8001_0000, 0, 0, 0));
      setcfg(0, 3'd5, 3'd3, 3'd0, 3'd0, 2'd1, 0, 2'd0, 0);
      xfer(mk(32'h8001_FFFF, 0, 0, 0), r, lf);
      chk("R3 widen one fill", r, ex(32'h8001_FF00, 0, 0, 0));
   endtask

   task automatic t_widen_lfsr; // R4
      logic [15:0] first;
      setcfg(0, 3'd7, 3'd1, 3'd0, 3'd0, 2'd2, 0, 2'd0, 0);
      xfer(mk(32'h5AC3_0000, 0, 0, 0), r, lf);
      first = lf;
      chk("R4 lfsr fill frame A", r, ex(32'h5A00_0000 | ({lf, lf} & 32'h00FF_FFFF), 0, 0, 0));
      xfer(mk(32'hA500_0000, 0, 0, 0), r, lf);
      chk("R4 lfsr fill frame B", r, ex(32'hA500_0000 | ({lf, lf} & 32'h00FF_FFFF), 0, 0, 0));
      chk("R4 lfsr advanced", {240'h0, lf}, {240'h0, first[14:0],
          first[15] ^ first[13] ^ first[12] ^ first[10]});
   endtask

   task automatic t_chop; // R5
      setcfg(0, 3'd1, 3'd5, 3'd0, 3'd0, 2'd0, 1, 2'd0, 0);
      xfer(mk(32'h12FF_FF00, 0, 0, 0), r, lf);
      chk("R5 chop 24 to 8", r, ex(32'h1200_0000, 0, 0, 0));
   endtask

   task automatic t_round; // R6
      setcfg(0, 3'd1, 3'd5, 3'd0, 3'd0, 2'd0, 0, 2'd0, 0);
      xfer(mk(32'h1280_0000, 0, 0, 0), r, lf);
      chk("R6 round up", r, ex(32'h1300_0000, 0, 0, 0));
      xfer(mk(32'h127F_FF00, 0, 0, 0), r, lf);
      chk("R6 round down", r, ex(32'h1200_0000, 0, 0, 0));
      xfer(mk(32'h7FC0_0000, 0, 0, 0), r, lf);
      chk("R6 saturate", r, ex(32'h7F00_0000, 0, 0, 0));
      xfer(mk(32'hFF80_0000, 0, 0, 0), r, lf);
      chk("R6 negative half", r, ex(32'h0000_0000, 0, 0, 0));
   endtask

   task automatic t_downmix; // R7
      setcfg(0, 3'd3, 3'd3, 3'd0, 3'd1, 2'd0, 0, 2'd0, 0);
      xfer(mk(32'h1000_0000, 32'h2000_0000, 0, 0), r, lf);
      chk("R7 take ch0", r, ex(32'h1000_0000, 0, 0, 0));
      setcfg(0, 3'd3, 3'd3, 3'd0, 3'd1, 2'd0, 0, 2'd1, 0);
      xfer(mk(32'h1000_0000, 32'h2000_0000, 0, 0), r, lf);
      chk("R7 take ch1", r, ex(32'h2000_0000, 0, 0, 0));
      setcfg(0, 3'd3, 3'd3, 3'd0, 3'd1, 2'd0, 0, 2'd2, 0);
      xfer(mk(32'h1000_0000, 32'h2000_0000, 0, 0), r, lf);
      chk("R7 mean", r, ex(32'h1800_0000, 0, 0, 0));
      xfer(mk(32'h8000_0000, 32'h8000_0000, 0, 0), r, lf);
      chk("R7 mean negative", r, ex(32'h8000_0000, 0, 0, 0));
      xfer(mk(32'h0003_0000, 32'h0000_0000, 0, 0), r, lf);
      chk("R7 mean odd floors", r, ex(32'h0001_0000, 0, 0, 0));
   endtask

   task automatic t_upmix; // R8
      setcfg(0, 3'd3, 3'd3, 3'd1, 3'd0, 2'd0, 0, 2'd0, 1);
      xfer(mk(32'hABCD_0000, 32'h5555_0000, 0, 0), r, lf);
      chk("R8 copy", r, ex(32'hABCD_0000, 32'hABCD_0000, 0, 0));
      setcfg(0, 3'd3, 3'd3, 3'd1, 3'd0, 2'd0, 0, 2'd0, 0);
      xfer(mk(32'hABCD_0000, 32'h5555_0000, 0, 0), r, lf);
      chk("R8 zero", r, ex(32'hABCD_0000, 0, 0, 0));
   endtask

   task automatic t_direction; // R2
      setcfg(1, 3'd1, 3'd3, 3'd0, 3'd0, 2'd1, 1, 2'd0, 0);
      xfer(mk(32'h1234_5678, 0, 0, 0), r, lf);
      chk("R2 dir1 hub to client", r, ex(32'h12FF_0000, 0, 0, 0));
      setcfg(0, 3'd1, 3'd3, 3'd0, 3'd0, 2'd1, 1, 2'd0, 0);
      xfer(mk(32'h1234_5678, 0, 0, 0), r, lf);
      chk("R2 dir0 client to hub", r, ex(32'h1200_0000, 0, 0, 0));
   endtask

   task automatic t_lanes; // R9
      setcfg(0, 3'd7, 3'd7, 3'd1, 3'd3, 2'd0, 0, 2'd0, 0);
      xfer(mk(32'hA1, 32'hB2, 32'hC3, 32'hD4), r, lf);
      chk("R9 four to two", r, ex(32'hA1, 32'hB2, 0, 0));
      setcfg(0, 3'd7, 3'd7, 3'd3, 3'd1, 2'd0, 0, 2'd0, 0);
      xfer(mk(32'hA1, 32'hB2, 32'hC3, 32'hD4), r, lf);
      chk("R9 two to four", r, ex(32'hA1, 32'hB2, 0, 0));
   endtask

   task automatic t_stall; // R10
      logic [BW-1:0] held;
      setcfg(0, 3'd7, 3'd7, 3'd0, 3'd0, 2'd0, 0, 2'd0, 0);
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_data = mk(32'h0BAD_F00D, 0, 0, 0);
      @(negedge clk);
      in_data = mk(32'h1357_9BDF, 0, 0, 0);
      held = out_data;
      chk("R10 stalled in_ready low", {255'h0, in_ready}, '0);
      repeat (3) @(negedge clk);
      chk("R10 held data", out_data, held);
      chk("R10 held value", out_data, ex(32'h0BAD_F00D, 0, 0, 0));
      chk("R10 held valid", {255'h0, out_valid}, {255'h0, 1'b1});
      in_valid = 1'b0; out_ready = 1'b1;
      @(negedge clk);
      chk("R10 drained", {255'h0, out_valid}, '0);
   endtask

   task automatic t_burst_cfg; // R11
      setcfg(0, 3'd3, 3'd3, 3'd0, 3'd0, 2'd0, 1, 2'd0, 0);
      @(negedge clk);
      out_ready = 1'b1; in_valid = 1'b1; in_data = mk(32'h1234_5678, 0, 0, 0);
      @(negedge clk);
      chk("R11 first of burst", out_data, ex(32'h1234_0000, 0, 0, 0));
      in_data = mk(32'h5678_9ABC, 0, 0, 0);
      cfg_hub_bits = 3'd1;                     // would narrow to 8 bits
      @(negedge clk);
      chk("R11 second keeps old width", out_data, ex(32'h5678_0000, 0, 0, 0));
      in_valid = 1'b0;
      @(negedge clk);
      xfer(mk(32'h5678_9ABC, 0, 0, 0), r, lf);
      chk("R11 new width after gap", r, ex(32'h5600_0000, 0, 0, 0));
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_passthru();
      t_widen_const();
      t_widen_lfsr();
      t_chop();
      t_round();
      t_downmix();
      t_upmix();
      t_direction();
      t_lanes();
      t_stall();
      t_burst_cfg();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule